// File: doc/BRIEF.md
# PCI Bridge I/O Window Decoder

This block makes the I/O routing decision for a PCI-to-PCI bridge. It holds two byte-wide configuration registers, the window floor and the window ceiling. Each register stores address bits 15:12 in its upper nibble, so the window is built from 4 KB pages inside a 16-bit I/O space. For every presented 32-bit I/O address and its side of origin, the block reports whether the access crosses the bridge.

Three control inputs adjust the decision. A space-enable input gates all forwarding. An ISA mode input stops the primary side from claiming the upper three quarters of every 4 KB page. A VGA mode input sends the legacy display port ranges downstream only, and it decodes just the ten low address bits. The decision is available combinationally, and the same decision is also registered one cycle later for timing closure.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, both registers read back 00h and `fwd_q` is 0.
- R2: A write with `cfg_sel`=0 updates the floor register and a write with `cfg_sel`=1 updates the ceiling register. Only bits 7:4 of the write data are stored. A read returns the stored nibble in bits 7:4 and 0h in bits 3:0. An unwritten register keeps its value.
- R3: With the ISA and VGA modes off, an address with bits 31:16 all zero lies inside the window when it is at least floor×1000h and at most ceiling×1000h+FFFh. A primary-side access (`io_from_sec`=0) inside the window is forwarded.
- R4: An address with any of bits 31:16 set is never inside the window.
- R5: When the ceiling is below the floor, the window is empty.
- R6: With ISA mode on, a primary-side access whose bits 11:0 are 400h or above is not forwarded through the window. ISA mode has no effect on secondary-side decisions.
- R7: With VGA mode on, a primary-side access is forwarded when bits 31:16 are zero and bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh. This holds whatever the value of bits 15:10 and whatever the window covers.
- R8: A secondary-side access that matches the VGA ranges is never forwarded.
- R9: A secondary-side access (`io_from_sec`=1) is forwarded only when it is outside the window and is not a VGA match.
- R10: While `io_space_en` is 0, nothing is forwarded in either direction.
- R11: `fwd_q` equals the value `fwd_now` had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | Register select: 0 floor, 1 ceiling |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for the selected register |
| io_space_en | input | 1 | Global I/O forwarding enable |
| isa_en | input | 1 | ISA alias exclusion mode |
| vga_en | input | 1 | VGA legacy range mode |
| io_addr | input | 32 | I/O address under decode |
| io_from_sec | input | 1 | Origin side: 0 primary, 1 secondary |
| fwd_now | output | 1 | Combinational forward decision |
| fwd_q | output | 1 | Forward decision registered one cycle later |

## Verification
The main sweep covers every floor and ceiling pair, including the empty pairs with the ceiling below the floor. For each pair it tries every page, both sides and all four ISA and VGA combinations. Within each page it uses offsets at 000h, 3BBh, 400h and FFFh, which separate the page edges, the ISA cut at 400h and a VGA hit. A second sweep moves bits 9:0 across the VGA ranges and their neighbours under changing bits 15:10, which checks the partial decode in both directions. Addresses with upper bits set, a run with the space enable cleared, and a stream of changing inputs checked one cycle later cover R4, R10 and R11.

// File: rtl/iow_pkg.sv
package iow_pkg;
    localparam int ADDR_W_DEF = 32;
    localparam int IO_W_DEF   = 16;
    localparam int GRAN_W_DEF = 12;
    localparam int CFG_W_DEF  = 8;
    localparam int LEG_W      = 10;

    localparam logic [LEG_W-1:0] MONO_LO  = 10'h3B0;
    localparam logic [LEG_W-1:0] MONO_HI  = 10'h3BB;
    localparam logic [LEG_W-1:0] COLOR_LO = 10'h3C0;
    localparam logic [LEG_W-1:0] COLOR_HI = 10'h3DF;

    typedef enum logic {
        SEL_FLOOR = 1'b0,
        SEL_CEIL  = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/iow_cfg_regs.sv
module iow_cfg_regs
    import iow_pkg::*;
#(
    parameter int CFG_W  = CFG_W_DEF,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [PAGE_W-1:0] floor_pg,
    output logic [PAGE_W-1:0] ceil_pg
);
    localparam int LOW_W = CFG_W - PAGE_W;

    typedef struct packed {
        logic [PAGE_W-1:0] floor_pg;
        logic [PAGE_W-1:0] ceil_pg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (cfg_sel_e'(sel) == SEL_FLOOR) cfg_d.floor_pg = wdata[CFG_W-1:LOW_W];
            else                              cfg_d.ceil_pg  = wdata[CFG_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign floor_pg = cfg_q.floor_pg;
    assign ceil_pg  = cfg_q.ceil_pg;
    assign rdata    = {(sel ? cfg_q.ceil_pg : cfg_q.floor_pg), {LOW_W{1'b0}}};

    assert_floor_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel) |=> (floor_pg == $past(wdata[CFG_W-1:LOW_W])));
    assert_ceil_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel) |=> $stable(ceil_pg));
endmodule

// File: rtl/iow_window_match.sv
module iow_window_match
    import iow_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int IO_W   = IO_W_DEF,
    parameter int GRAN_W = GRAN_W_DEF
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [IO_W-GRAN_W-1:0] floor_pg,
    input  logic [IO_W-GRAN_W-1:0] ceil_pg,
    output logic                   hi_zero,
    output logic                   in_win
);
    localparam int PAGE_W = IO_W - GRAN_W;

    logic [PAGE_W-1:0] page;

    always_comb begin
        hi_zero = (addr[ADDR_W-1:IO_W] == '0);
        page    = addr[IO_W-1:GRAN_W];
        in_win  = hi_zero && (page >= floor_pg) && (page <= ceil_pg);
    end
endmodule

// File: rtl/iow_legacy_match.sv
module iow_legacy_match
    import iow_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int GRAN_W = GRAN_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hi_zero,
    input  logic              isa_en,
    input  logic              vga_en,
    output logic              isa_excl,
    output logic              vga_hit
);
    localparam int ALIAS_W = GRAN_W - LEG_W;

    logic [LEG_W-1:0] low;

    always_comb begin
        low      = addr[LEG_W-1:0];
        isa_excl = isa_en && (addr[GRAN_W-1:LEG_W] != {ALIAS_W{1'b0}});
        vga_hit  = vga_en && hi_zero &&
                   (((low >= MONO_LO)  && (low <= MONO_HI)) ||
                    ((low >= COLOR_LO) && (low <= COLOR_HI)));
    end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import iow_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int IO_W   = IO_W_DEF,
    parameter int GRAN_W = GRAN_W_DEF,
    parameter int CFG_W  = CFG_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              io_space_en,
    input  logic              isa_en,
    input  logic              vga_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_from_sec,
    output logic              fwd_now,
    output logic              fwd_q
);
    localparam int PAGE_W = IO_W - GRAN_W;

    typedef struct packed {
        logic fwd;
    } out_t;

    out_t out_d, out_q;

    logic [PAGE_W-1:0] floor_pg, ceil_pg;
    logic              hi_zero, in_win, isa_excl, vga_hit;

    iow_cfg_regs #(.CFG_W(CFG_W), .PAGE_W(PAGE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .floor_pg (floor_pg),
        .ceil_pg  (ceil_pg)
    );

    iow_window_match #(.ADDR_W(ADDR_W), .IO_W(IO_W), .GRAN_W(GRAN_W)) u_win (
        .addr     (io_addr),
        .floor_pg (floor_pg),
        .ceil_pg  (ceil_pg),
        .hi_zero  (hi_zero),
        .in_win   (in_win)
    );

    iow_legacy_match #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_leg (
        .addr     (io_addr),
        .hi_zero  (hi_zero),
        .isa_en   (isa_en),
        .vga_en   (vga_en),
        .isa_excl (isa_excl),
        .vga_hit  (vga_hit)
    );

    always_comb begin
        out_d = out_q;
        if (!io_space_en)     out_d.fwd = 1'b0;
        else if (io_from_sec) out_d.fwd = !in_win && !vga_hit;
        else                  out_d.fwd = (in_win && !isa_excl) || vga_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fwd_now = out_d.fwd;
    assign fwd_q   = out_q.fwd;

    assert_space_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_space_en) |-> !fwd_q);
    assert_sec_vga_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_from_sec && vga_hit) |-> !fwd_now);
    assert_isa_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_from_sec && isa_excl && !vga_hit) |-> !fwd_now);
    assert_upper_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[ADDR_W-1:IO_W] != '0) |-> !in_win);
    assert_empty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_pg < floor_pg) |-> !in_win);
endmodule

// File: tb/io_window_decoder_test.sv
module io_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        io_space_en = 1'b0;
    logic        isa_en = 1'b0;
    logic        vga_en = 1'b0;
    logic [31:0] io_addr = 32'h0;
    logic        io_from_sec = 1'b0;
    logic        fwd_now, fwd_q;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    io_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_space_en(io_space_en),
        .isa_en(isa_en), .vga_en(vga_en), .io_addr(io_addr),
        .io_from_sec(io_from_sec), .fwd_now(fwd_now), .fwd_q(fwd_q)
    );

    function automatic bit model(int fl, int ce, logic [31:0] a, bit sec,
                                 bit en, bit isa, bit vga);
        longint ua = a;
        bit inw = (ua < 65536) && (ua >= fl * 4096) && (ua <= ce * 4096 + 4095);
        bit excl = isa && ((ua % 4096) >= 1024);
        int lo = int'(ua % 1024);
        bit vh = vga && (ua < 65536) &&
                 ((lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF));
        if (!en) return 1'b0;
        if (sec) return !inw && !vh;
        return (inw && !excl) || vh;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, io_addr, act, exp);
        end
    endtask

    task automatic write_cfg(bit sel, logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic apply(string req, int fl, int ce, logic [31:0] a, bit sec);
        io_addr = a; io_from_sec = sec;
        #1;
        check(req, {31'b0, fwd_now},
              {31'b0, model(fl, ce, a, sec, io_space_en, isa_en, vga_en)});
        #1;
    endtask

    task automatic run_all();
        bit pend;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        cfg_sel = 1'b0; #1; check("R1", {24'b0, cfg_rdata}, 32'h00);
        cfg_sel = 1'b1; #1; check("R1", {24'b0, cfg_rdata}, 32'h00);
        check("R1", {31'b0, fwd_q}, 32'h0);
        rst_n = 1'b1;

        // R2: nibble storage, read-only low nibble, separate registers
        write_cfg(1'b0, 8'hA7);
        cfg_sel = 1'b0; #1; check("R2", {24'b0, cfg_rdata}, 32'hA0);
        cfg_sel = 1'b1; #1; check("R2", {24'b0, cfg_rdata}, 32'h00);
        write_cfg(1'b1, 8'h5F);
        cfg_sel = 1'b1; #1; check("R2", {24'b0, cfg_rdata}, 32'h50);
        cfg_sel = 1'b0; #1; check("R2", {24'b0, cfg_rdata}, 32'hA0);

        // R3 R5 R6 R7 R9: full pair sweep
        io_space_en = 1'b1;
        for (int fl = 0; fl < 16; fl++) begin
            write_cfg(1'b0, 8'(fl << 4));
            for (int ce = 0; ce < 16; ce++) begin
                write_cfg(1'b1, 8'(ce << 4) | 8'h0C);
                for (int m = 0; m < 4; m++) begin
                    isa_en = m[0]; vga_en = m[1];
                    for (int pg = 0; pg < 16; pg++)
                        for (int o = 0; o < 4; o++)
                            for (int s = 0; s < 2; s++) begin
                                logic [11:0] off;
                                off = (o == 0) ? 12'h000 : (o == 1) ? 12'h3BB :
                                      (o == 2) ? 12'h400 : 12'hFFF;
                                apply(ce < fl ? "R5" : (m == 0 ? (s ? "R9" : "R3") :
                                      (m == 1 ? "R6" : "R7")),
                                      fl, ce, {16'h0, 4'(pg), off}, s[0]);
                            end
                end
            end
        end

        // R7 R8: VGA partial decode with varied bits 15:10, window empty
        write_cfg(1'b0, 8'hF0);
        write_cfg(1'b1, 8'h00);
        isa_en = 1'b1; vga_en = 1'b1;
        for (int hi = 0; hi < 64; hi += 7)
            for (int lo = 'h3A0; lo < 'h3F0; lo++)
                for (int s = 0; s < 2; s++)
                    apply(s ? "R8" : "R7", 15, 0, {16'h0, 6'(hi), 10'(lo)}, s[0]);

        // R4: upper address bits set, full window
        write_cfg(1'b0, 8'h00);
        write_cfg(1'b1, 8'hF0);
        isa_en = 1'b0;
        for (int u = 0; u < 16; u++)
            for (int s = 0; s < 2; s++)
                apply("R4", 0, 15, {16'(1 << u), 16'h3C4}, s[0]);

        // R10: space enable cleared
        io_space_en = 1'b0;
        for (int pg = 0; pg < 16; pg++)
            for (int s = 0; s < 2; s++)
                apply("R10", 0, 15, {16'h0, 4'(pg), 12'h3C0}, s[0]);

        // R11: registered decision one cycle later
        write_cfg(1'b0, 8'h30);
        write_cfg(1'b1, 8'h60);
        vga_en = 1'b0;
        @(negedge clk);
        pend = 1'b0;
        for (int k = 0; k < 24; k++) begin
            io_space_en = (k % 5) != 0;
            io_from_sec = k[0];
            io_addr = {16'h0, 4'(k), 12'h123};
            @(negedge clk);
            check("R11", {31'b0, fwd_q},
                  {31'b0, model(3, 6, {16'h0, 4'(k), 12'h123}, k[0], (k % 5) != 0, 1'b0, 1'b0)});
            pend = fwd_q;
        end
        if (pend) io_space_en = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule